// File: doc/BRIEF.md
# Precision-Scalable Signed Sub-word Multiplier

This block multiplies two 8-bit operands, `x` and `w`, through one shared array of four 4x4 nibble multipliers. A 3-bit mode input reconfigures the array. It can form one signed 8x8 product, four independent signed 4x4 products, or two signed 4x8 or 8x4 lane products. Each operand is split into a low and a high nibble. The four nibble products are either fused by a carry-save reduction into one wide product or kept apart as packed lanes.

Each nibble multiplier receives a signedness flag per operand. A low nibble counts as unsigned when it is the lower half of an 8-bit signed value, and as signed when it is a value of its own. A live flag turns every nibble multiplier off for mode codes that are not defined. The result is registered once, so a product appears on `prod` one clock after its operands are presented.

Top module: `subword_mul`

## Requirements
- R1: Mode 000 (full): `prod[15:0]` is the signed product of `x` and `w`, and `prod[31:16]` copies `prod[15]`.
- R2: Mode 001 (quad): the nibbles are signed 4-bit values. Byte 0 of `prod` holds `x[3:0]*w[3:0]`, byte 1 holds `x[3:0]*w[7:4]`, byte 2 holds `x[7:4]*w[3:0]` and byte 3 holds `x[7:4]*w[7:4]`.
- R3: Mode 010 (x-nibble): `prod[15:0]` is the sign-extended product of signed `x[3:0]` and signed `w`, and `prod[31:16]` is the same for signed `x[7:4]`.
- R4: Mode 011 (w-nibble): `prod[15:0]` is the sign-extended product of signed `x` and signed `w[3:0]`, and `prod[31:16]` is the same for signed `w[7:4]`.
- R5: Mode codes 100 through 111 give an all-zero `prod`.
- R6: `prod` changes only at a rising clock edge. It shows the result of the inputs sampled at that edge.
- R7: When `rst` is high at a rising edge, `prod` becomes zero whatever the inputs are.
- R8: A change of mode from one cycle to the next takes full effect in the next result, and nothing is carried over from the previous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Configuration code |
| x | input | 8 | First operand |
| w | input | 8 | Second operand |
| prod | output | 32 | Registered result, one product or packed lanes |

## Verification
The hardest case to reach is a mix of signedness rules within one fused product. An example is a low nibble of 1000 that must count as +8 while the high nibble of the same operand counts as negative. The same bit pattern must count as -8 when the mode changes one cycle later. Directed operands such as 0x88, 0x80, 0x08 and 0x7F are therefore run in every mode code. Randomly chosen modes then change on every cycle, so that a stale signedness flag or a stale lane arrangement shows up in the very next result.

// File: rtl/sw_pkg.sv
package sw_pkg;

    typedef enum logic [2:0] {
        MODE_FULL = 3'b000,
        MODE_QUAD = 3'b001,
        MODE_XNIB = 3'b010,
        MODE_WNIB = 3'b011
    } sw_mode_e;

    // per-nibble signedness plus the live gate for the whole array
    typedef struct packed {
        logic xl_s;
        logic xh_s;
        logic wl_s;
        logic wh_s;
        logic live;
    } nib_ctrl_t;

    function automatic nib_ctrl_t ctrl_for(input logic [2:0] code);
        nib_ctrl_t c;
        c = '{xl_s: 1'b0, xh_s: 1'b0, wl_s: 1'b0, wh_s: 1'b0, live: 1'b0};
        case (code)
            MODE_FULL: c = '{xl_s: 1'b0, xh_s: 1'b1, wl_s: 1'b0, wh_s: 1'b1, live: 1'b1};
            MODE_QUAD: c = '{xl_s: 1'b1, xh_s: 1'b1, wl_s: 1'b1, wh_s: 1'b1, live: 1'b1};
            MODE_XNIB: c = '{xl_s: 1'b1, xh_s: 1'b1, wl_s: 1'b0, wh_s: 1'b1, live: 1'b1};
            MODE_WNIB: c = '{xl_s: 1'b0, xh_s: 1'b1, wl_s: 1'b1, wh_s: 1'b1, live: 1'b1};
            default:   c = '{xl_s: 1'b0, xh_s: 1'b0, wl_s: 1'b0, wh_s: 1'b0, live: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sw_nibble_mul.sv
module sw_nibble_mul #(
    parameter int NIB = 4,
    localparam int PWD = 2 * NIB + 2
) (
    input  logic [NIB-1:0] a,
    input  logic [NIB-1:0] b,
    input  logic           a_s,
    input  logic           b_s,
    input  logic           live,
    output logic [PWD-1:0] p
);
    logic [PWD-1:0] ax, bx;

    // widen each nibble by sign or zero, depending on its flag
    assign ax = {{(NIB + 2){a_s & a[NIB-1]}}, a};
    assign bx = {{(NIB + 2){b_s & b[NIB-1]}}, b};

    // low PWD bits of the product are exact: the true product fits
    assign p = live ? PWD'(ax * bx) : '0;
endmodule

// File: rtl/sw_csa_tree.sv
module sw_csa_tree #(
    parameter int W = 16
) (
    input  logic [W-1:0] t0,
    input  logic [W-1:0] t1,
    input  logic [W-1:0] t2,
    input  logic [W-1:0] t3,
    output logic [W-1:0] sum
);
    logic [W-1:0] s1, c1, s2, c2;

    always_comb begin
        // first 3:2 layer
        s1 = t0 ^ t1 ^ t2;
        c1 = ((t0 & t1) | (t0 & t2) | (t1 & t2)) << 1;
        // second 3:2 layer folds in the last term
        s2 = s1 ^ c1 ^ t3;
        c2 = ((s1 & c1) | (s1 & t3) | (c1 & t3)) << 1;
        // single carry-propagate add
        sum = s2 + c2;
    end
endmodule

// File: rtl/sw_lane_pack.sv
module sw_lane_pack
    import sw_pkg::*;
#(
    parameter int NIB = 4,
    localparam int PWD = 2 * NIB + 2,
    localparam int HW  = 4 * NIB,
    localparam int OW  = 8 * NIB,
    localparam int BW  = 2 * NIB
) (
    input  logic [2:0]     mode,
    input  logic [PWD-1:0] p0,
    input  logic [PWD-1:0] p1,
    input  logic [PWD-1:0] p2,
    input  logic [PWD-1:0] p3,
    input  logic [HW-1:0]  fused,
    output logic [OW-1:0]  packed_out
);
    logic [HW-1:0] e0, e1, e2, e3;
    logic [HW-1:0] xn_lo, xn_hi, wn_lo, wn_hi;

    assign e0 = {{(HW - PWD){p0[PWD-1]}}, p0};
    assign e1 = {{(HW - PWD){p1[PWD-1]}}, p1};
    assign e2 = {{(HW - PWD){p2[PWD-1]}}, p2};
    assign e3 = {{(HW - PWD){p3[PWD-1]}}, p3};

    // one nibble of x against all of w
    assign xn_lo = e0 + (e1 << NIB);
    assign xn_hi = e2 + (e3 << NIB);
    // all of x against one nibble of w
    assign wn_lo = e0 + (e2 << NIB);
    assign wn_hi = e1 + (e3 << NIB);

    always_comb begin
        case (mode)
            MODE_FULL: packed_out = {{HW{fused[HW-1]}}, fused};
            MODE_QUAD: packed_out = {p3[BW-1:0], p2[BW-1:0], p1[BW-1:0], p0[BW-1:0]};
            MODE_XNIB: packed_out = {xn_hi, xn_lo};
            MODE_WNIB: packed_out = {wn_hi, wn_lo};
            default:   packed_out = '0;
        endcase
    end
endmodule

// File: rtl/subword_mul.sv
module subword_mul
    import sw_pkg::*;
#(
    parameter int NIB = 4,
    localparam int OPW = 2 * NIB,
    localparam int PWD = 2 * NIB + 2,
    localparam int HW  = 4 * NIB,
    localparam int OW  = 8 * NIB
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2:0]     mode,
    input  logic [OPW-1:0] x,
    input  logic [OPW-1:0] w,
    output logic [OW-1:0]  prod
);
    nib_ctrl_t      ctrl;
    logic [NIB-1:0] xn [2];
    logic [NIB-1:0] wn [2];
    logic           xs [2];
    logic           ws [2];
    logic [PWD-1:0] pp [4];
    logic [HW-1:0]  fused;
    logic [OW-1:0]  comb_out;

    assign ctrl  = ctrl_for(mode);
    assign xn[0] = x[NIB-1:0];
    assign xn[1] = x[OPW-1:NIB];
    assign wn[0] = w[NIB-1:0];
    assign wn[1] = w[OPW-1:NIB];
    assign xs[0] = ctrl.xl_s;
    assign xs[1] = ctrl.xh_s;
    assign ws[0] = ctrl.wl_s;
    assign ws[1] = ctrl.wh_s;

    // product i uses x nibble i[1] and w nibble i[0]
    for (genvar i = 0; i < 4; i++) begin : g_nib
        localparam int XI = i / 2;
        localparam int WI = i % 2;
        sw_nibble_mul #(.NIB(NIB)) u_mul (
            .a    (xn[XI]),
            .b    (wn[WI]),
            .a_s  (xs[XI]),
            .b_s  (ws[WI]),
            .live (ctrl.live),
            .p    (pp[i])
        );
    end

    logic [HW-1:0] sx [4];
    for (genvar i = 0; i < 4; i++) begin : g_ext
        assign sx[i] = {{(HW - PWD){pp[i][PWD-1]}}, pp[i]};
    end

    sw_csa_tree #(.W(HW)) u_tree (
        .t0  (sx[0]),
        .t1  (sx[1] << NIB),
        .t2  (sx[2] << NIB),
        .t3  (sx[3] << (2 * NIB)),
        .sum (fused)
    );

    sw_lane_pack #(.NIB(NIB)) u_pack (
        .mode       (mode),
        .p0         (pp[0]),
        .p1         (pp[1]),
        .p2         (pp[2]),
        .p3         (pp[3]),
        .fused      (fused),
        .packed_out (comb_out)
    );

    always_ff @(posedge clk) begin
        if (rst) prod <= '0;
        else     prod <= comb_out;
    end

    // R5
    undefined_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        mode[2] |=> (prod == '0));

    // R1
    full_sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FULL) |=> (prod[OW-1:HW] == {HW{prod[HW-1]}}));

    // R3
    xnib_lane_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_XNIB) |=> (prod[HW-1:3*NIB] == {NIB{prod[3*NIB-1]}})
                             && (prod[OW-1:7*NIB] == {NIB{prod[7*NIB-1]}}));

    // R4
    wnib_lane_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WNIB) |=> (prod[HW-1:3*NIB] == {NIB{prod[3*NIB-1]}})
                             && (prod[OW-1:7*NIB] == {NIB{prod[7*NIB-1]}}));

    // R2
    quad_zero_x_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_QUAD && x == '0) |=> (prod == '0));

    // R6
    hold_between_edges_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && $past(!rst) && $stable(mode) && $stable(x) && $stable(w)) |=> $stable(prod));
endmodule

// File: tb/subword_mul_test.sv
module subword_mul_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = '0;
    logic [7:0]  x = '0;
    logic [7:0]  w = '0;
    logic [31:0] prod;

    int n_tests = 0;
    int n_fail  = 0;
    logic        pending = 1'b0;
    logic [31:0] exp_q = '0;
    string       tag_q = "";

    always #5 clk = ~clk;

    subword_mul uut (.clk(clk), .rst(rst), .mode(mode), .x(x), .w(w), .prod(prod));

    function automatic int s4(input logic [3:0] n);
        return int'($signed(n));
    endfunction

    function automatic int s8(input logic [7:0] n);
        return int'($signed(n));
    endfunction

    function automatic logic [31:0] model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        int p, q, r0, r1, r2, r3;
        logic [31:0] pv, qv, r;
        r = '0;
        case (m)
            3'b000: begin p = s8(a) * s8(b); r = p; end
            3'b001: begin
                r0 = s4(a[3:0]) * s4(b[3:0]);
                r1 = s4(a[3:0]) * s4(b[7:4]);
                r2 = s4(a[7:4]) * s4(b[3:0]);
                r3 = s4(a[7:4]) * s4(b[7:4]);
                pv = r0; qv = r1; r[7:0] = pv[7:0]; r[15:8] = qv[7:0];
                pv = r2; qv = r3; r[23:16] = pv[7:0]; r[31:24] = qv[7:0];
            end
            3'b010: begin
                p = s4(a[3:0]) * s8(b); q = s4(a[7:4]) * s8(b);
                pv = p; qv = q; r = {qv[15:0], pv[15:0]};
            end
            3'b011: begin
                p = s8(a) * s4(b[3:0]); q = s8(a) * s4(b[7:4]);
                pv = p; qv = q; r = {qv[15:0], pv[15:0]};
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        n_tests++;
        if (prod !== exp) begin
            n_fail++;
            $display("FAIL %s: prod=%h expected=%h", tag, prod, exp);
        end
    endtask

    // check the previous vector, then present the next one
    task automatic step(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b, input string extra);
        @(negedge clk);
        if (pending) check(tag_q, exp_q);
        mode = m; x = a; w = b;
        exp_q = model(m, a, b);
        tag_q = {mode_tag(m), extra};
        pending = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pending) check(tag_q, exp_q);
        pending = 1'b0;
    endtask

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] corners [7];
        void'($urandom(32'd4711));
        corners = '{8'h80, 8'h7F, 8'hFF, 8'h00, 8'h88, 8'h08, 8'h78};

        // R7: reset clears the output even with busy inputs
        @(negedge clk);
        mode = 3'b000; x = 8'h80; w = 8'h80;
        @(negedge clk);
        check("R7 reset", 32'h0);
        mode = 3'b001; x = 8'hFF; w = 8'h77;
        @(negedge clk);
        check("R7 reset", 32'h0);
        rst = 1'b0;

        // R1..R5 directed corners in every code
        for (int m = 0; m < 8; m++)
            for (int i = 0; i < 7; i++)
                for (int j = 0; j < 7; j++)
                    step(3'(m), corners[i], corners[j], " corner");
        flush();

        // R6: output holds until the edge after the inputs change
        step(3'b000, 8'h05, 8'h07, " R6 setup");
        flush();
        @(negedge clk);
        mode = 3'b000; x = 8'h80; w = 8'h7F;
        #2;
        check("R6 before edge", model(3'b000, 8'h05, 8'h07));
        @(negedge clk);
        check("R6 after edge", model(3'b000, 8'h80, 8'h7F));

        // R8: same operands, code changes on each cycle
        for (int k = 0; k < 3; k++)
            for (int m = 0; m < 8; m++)
                step(3'(m), 8'h9C, 8'hE3, " R8 switch");
        flush();

        // random operands and codes, mode changes every cycle
        for (int n = 0; n < 20000; n++)
            step(3'($urandom % 8), 8'($urandom), 8'($urandom), " R8 random");
        flush();

        // R7: reset mid-stream
        @(negedge clk);
        mode = 3'b000; x = 8'h81; w = 8'h81; rst = 1'b1;
        @(negedge clk);
        check("R7 mid reset", 32'h0);
        rst = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule